// File: doc/BRIEF.md
# Tandem Connection Outgoing Defect Indication Generator

This block decides the outgoing defect indication bit that a tributary channel places in its tandem connection overhead byte. Once per 76-frame multiframe, that byte's defect bit is filled in during one frame. The block turns a set of level-sensitive receive-side alarm conditions into a single defect request. Some of these alarms are always honoured. Others count only when their own qualifying enable is set. A software force request is also taken into account.

The defect request is sampled only at the insertion point, which is the overhead byte slot of frame 74. When the request is present there, a repeat counter is loaded so that the indication keeps going out for a minimum number of multiframes, even if the alarm has already gone away. The surrounding byte assembler receives an insertion strobe together with the bit value. It places the value at bit 7 of the byte, counting bits 1 to 8 from the most significant end, only while the strobe is high.

Top module: `tc_odi_gen`

## Requirements
- R1: A synchronous active-high reset clears the repeat count, so the first insertion point after reset with no alarm active gives `odi_val` = 0, even if a repeat was in progress when reset arrived.
- R2: `odi_ins` is 1 exactly when `n2_slot` is 1 and `frame_num` equals 74, where frames are numbered 1 to 76. It is 0 in every other frame and whenever `n2_slot` is 0.
- R3: `odi_val` is 0 in every cycle in which `odi_ins` is 0.
- R4: Each bit of `alm_direct` triggers the indication with no enable. The bit positions are 0 loss of pointer, 1 tributary AIS, 2 TC loss of multiframe, 3 TC loss of lock, 4 TC trace mismatch, 5 TC unequipped.
- R5: Each bit of `alm_gated` triggers only when the same bit of `gate_en` is 1. The bit positions are 0 unequipped label, 1 label mismatch, 2 trace loss of lock, 3 trace mismatch, 4 container AIS.
- R6: `drop_loc` triggers only when `loc_en` is 1. `drop_ais` triggers only when both `ais_en_a` and `ais_en_b` are 1.
- R7: `tc_ais` triggers only when both `tc_enable` and `tc_ais_en` are 1.
- R8: `sw_force` = 1 makes `odi_val` = 1 at every insertion point, whatever the alarm state.
- R9: A trigger present at one insertion point gives `odi_val` = 1 at that point and at the following 9 insertion points (10 in all). If no trigger is present meanwhile, the 11th point gives 0.
- R10: A trigger present at a later insertion point, while a repeat is still running, restarts the full 10-point window from that point.
- R11: Alarms are sampled only at insertion points. An alarm that is active only between insertion points has no effect on `odi_val`.

Top module ports appear below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_num | input | 7 | Current frame within the multiframe, 1..76 |
| n2_slot | input | 1 | High in the cycle the tandem overhead byte is assembled |
| alm_direct | input | 6 | Alarms that trigger with no enable |
| alm_gated | input | 5 | Alarms that each need their own enable |
| gate_en | input | 5 | Per-bit enables for `alm_gated` |
| drop_loc | input | 1 | Drop bus loss of clock |
| loc_en | input | 1 | Enable for `drop_loc` |
| drop_ais | input | 1 | Drop bus AIS |
| ais_en_a | input | 1 | First enable for `drop_ais` |
| ais_en_b | input | 1 | Second enable for `drop_ais` |
| tc_ais | input | 1 | TC AIS detected |
| tc_enable | input | 1 | Tandem connection feature enabled |
| tc_ais_en | input | 1 | Enable for `tc_ais` |
| sw_force | input | 1 | Software request to send the indication |
| odi_ins | output | 1 | Insertion strobe for the defect bit |
| odi_val | output | 1 | Defect bit value, valid while `odi_ins` is high |

## Verification
The hardest situation to reach is a retrigger part way through a repeat window. Just as hard is an alarm that comes and goes strictly between two insertion points. In both, a wrong count can look correct for many multiframes before it shows. The stimulus drives only the frame-74 slot as its unit of time and keeps a running model of the remaining repeats. It then places triggers a few insertion points apart and holds alarms high while `n2_slot` is low or another frame number is shown. Every alarm and enable combination is swept one case at a time, and each case drains through the full window, so every case also exercises the countdown and its end.

// File: rtl/tc_odi_pkg.sv
package tc_odi_pkg;
   localparam int N_DIRECT = 6;
   localparam int N_GATED  = 5;

   typedef enum int {
      DIR_LOP    = 0,
      DIR_TUAIS  = 1,
      DIR_TCLOM  = 2,
      DIR_TCLOL  = 3,
      DIR_TCTIM  = 4,
      DIR_TCUNEQ = 5
   } direct_idx_e;

   typedef enum int {
      GAT_UNEQ   = 0,
      GAT_PLM    = 1,
      GAT_TRLOL  = 2,
      GAT_TRTIM  = 3,
      GAT_VCAIS  = 4
   } gated_idx_e;
endpackage

// File: rtl/tc_odi_slot.sv
module tc_odi_slot #(
   parameter int MFRAME_LEN = 76,
   parameter int ODI_FRAME  = 74,
   localparam int FRAME_W   = $clog2(MFRAME_LEN + 1)
) (
   input  logic               n2_slot,
   input  logic [FRAME_W-1:0] frame_num,
   output logic               ins
);
   if (ODI_FRAME < 1 || ODI_FRAME > MFRAME_LEN) begin : g_bad_frame
      $error("ODI_FRAME must lie within 1..MFRAME_LEN");
   end

   localparam logic [FRAME_W-1:0] SLOT_FRAME = FRAME_W'(ODI_FRAME);

   always_comb begin
      ins = n2_slot && (frame_num == SLOT_FRAME);
   end
endmodule

// File: rtl/tc_odi_qualify.sv
module tc_odi_qualify
   import tc_odi_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic [N_DIRECT-1:0] alm_direct,
   input  logic [N_GATED-1:0]  alm_gated,
   input  logic [N_GATED-1:0]  gate_en,
   input  logic                drop_loc,
   input  logic                loc_en,
   input  logic                drop_ais,
   input  logic                ais_en_a,
   input  logic                ais_en_b,
   input  logic                tc_ais,
   input  logic                tc_enable,
   input  logic                tc_ais_en,
   input  logic                sw_force,
   output logic                trig
);
   logic [N_GATED-1:0] gated_q;
   logic               misc_q;

   for (genvar gi = 0; gi < N_GATED; gi++) begin : g_gate
      always_comb gated_q[gi] = alm_gated[gi] & gate_en[gi];
   end

   always_comb begin
      misc_q = (drop_loc & loc_en)
             | (drop_ais & ais_en_a & ais_en_b)
             | (tc_ais & tc_enable & tc_ais_en);
      trig   = (|alm_direct) | (|gated_q) | misc_q | sw_force;
   end

   // R6: drop AIS alone, with either enable low, never raises the trigger
   a_r6_ais_needs_both: assert property (@(posedge clk) disable iff (rst)
      (drop_ais && !(ais_en_a && ais_en_b) && alm_direct == '0 && gated_q == '0
       && !(drop_loc && loc_en) && !(tc_ais && tc_enable && tc_ais_en) && !sw_force)
      |-> !trig);
   // R7: TC AIS with the feature off cannot be the only cause
   a_r7_tcais_gated: assert property (@(posedge clk) disable iff (rst)
      (!tc_enable && alm_direct == '0 && alm_gated == '0 && !drop_loc && !drop_ais && !sw_force)
      |-> !trig);
endmodule

// File: rtl/tc_odi_stretch.sv
module tc_odi_stretch #(
   parameter int MIN_REPEAT = 10,
   localparam int CNT_W     = (MIN_REPEAT > 1) ? $clog2(MIN_REPEAT) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic ins,
   input  logic trig,
   output logic active
);
   if (MIN_REPEAT < 1) begin : g_bad_rep
      $error("MIN_REPEAT must be at least 1");
   end

   if (MIN_REPEAT > 1) begin : g_count
      localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MIN_REPEAT - 1);
      logic [CNT_W-1:0] rem;

      always_ff @(posedge clk) begin
         if (rst) begin
            rem <= '0;
         end else if (ins) begin
            if (trig)
               rem <= RELOAD;
            else if (rem != '0)
               rem <= rem - 1'b1;
         end
      end

      always_comb active = trig | (rem != '0);

      // R10: a trigger at an insertion point loads the full window
      a_r10_reload: assert property (@(posedge clk) disable iff (rst)
         (ins && trig) |=> (rem == RELOAD));
      // R9: without a trigger the count drops by one per insertion point
      a_r9_countdown: assert property (@(posedge clk) disable iff (rst)
         (ins && !trig && rem != '0) |=> (rem == $past(rem) - 1'b1));
      // R11: nothing outside an insertion point moves the count
      a_r11_hold: assert property (@(posedge clk) disable iff (rst)
         !ins |=> $stable(rem));
   end else begin : g_pass
      always_comb active = trig;
   end
endmodule

// File: rtl/tc_odi_gen.sv
module tc_odi_gen
   import tc_odi_pkg::*;
#(
   parameter int MFRAME_LEN = 76,
   parameter int ODI_FRAME  = 74,
   parameter int MIN_REPEAT = 10,
   localparam int FRAME_W   = $clog2(MFRAME_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [FRAME_W-1:0]  frame_num,
   input  logic                n2_slot,
   input  logic [N_DIRECT-1:0] alm_direct,
   input  logic [N_GATED-1:0]  alm_gated,
   input  logic [N_GATED-1:0]  gate_en,
   input  logic                drop_loc,
   input  logic                loc_en,
   input  logic                drop_ais,
   input  logic                ais_en_a,
   input  logic                ais_en_b,
   input  logic                tc_ais,
   input  logic                tc_enable,
   input  logic                tc_ais_en,
   input  logic                sw_force,
   output logic                odi_ins,
   output logic                odi_val
);
   logic trig;
   logic active;

   tc_odi_slot #(.MFRAME_LEN(MFRAME_LEN), .ODI_FRAME(ODI_FRAME)) u_slot (
      .n2_slot  (n2_slot),
      .frame_num(frame_num),
      .ins      (odi_ins)
   );

   tc_odi_qualify u_qual (
      .clk       (clk),
      .rst       (rst),
      .alm_direct(alm_direct),
      .alm_gated (alm_gated),
      .gate_en   (gate_en),
      .drop_loc  (drop_loc),
      .loc_en    (loc_en),
      .drop_ais  (drop_ais),
      .ais_en_a  (ais_en_a),
      .ais_en_b  (ais_en_b),
      .tc_ais    (tc_ais),
      .tc_enable (tc_enable),
      .tc_ais_en (tc_ais_en),
      .sw_force  (sw_force),
      .trig      (trig)
   );

   tc_odi_stretch #(.MIN_REPEAT(MIN_REPEAT)) u_str (
      .clk   (clk),
      .rst   (rst),
      .ins   (odi_ins),
      .trig  (trig),
      .active(active)
   );

   always_comb odi_val = odi_ins & active;

   // R3: the bit value is quiet outside the insertion strobe
   a_r3_quiet_outside: assert property (@(posedge clk) disable iff (rst)
      !odi_ins |-> !odi_val);
   // R2: the strobe needs the overhead slot
   a_r2_needs_slot: assert property (@(posedge clk) disable iff (rst)
      odi_ins |-> n2_slot);
   // R8: a software force always shows at an insertion point
   a_r8_force: assert property (@(posedge clk) disable iff (rst)
      (sw_force && odi_ins) |-> odi_val);
   // R4: any direct alarm shows at an insertion point
   a_r4_direct: assert property (@(posedge clk) disable iff (rst)
      (alm_direct != '0 && odi_ins) |-> odi_val);
endmodule

// File: tb/tc_odi_gen_test.sv
`timescale 1ns/100ps
module tc_odi_gen_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] frame_num = 7'd1;
   logic       n2_slot = 1'b0;
   logic [5:0] alm_direct = '0;
   logic [4:0] alm_gated = '0;
   logic [4:0] gate_en = '0;
   logic drop_loc = 0, loc_en = 0, drop_ais = 0, ais_en_a = 0, ais_en_b = 0;
   logic tc_ais = 0, tc_enable = 0, tc_ais_en = 0, sw_force = 0;
   logic odi_ins, odi_val;

   int n_chk = 0;
   int n_bad = 0;
   int mrem = 0;

   always #2.5 clk = ~clk;

   tc_odi_gen uut (
      .clk(clk), .rst(rst), .frame_num(frame_num), .n2_slot(n2_slot),
      .alm_direct(alm_direct), .alm_gated(alm_gated), .gate_en(gate_en),
      .drop_loc(drop_loc), .loc_en(loc_en), .drop_ais(drop_ais),
      .ais_en_a(ais_en_a), .ais_en_b(ais_en_b), .tc_ais(tc_ais),
      .tc_enable(tc_enable), .tc_ais_en(tc_ais_en), .sw_force(sw_force),
      .odi_ins(odi_ins), .odi_val(odi_val)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_alarms();
      alm_direct = '0; alm_gated = '0; gate_en = '0;
      drop_loc = 0; loc_en = 0; drop_ais = 0; ais_en_a = 0; ais_en_b = 0;
      tc_ais = 0; tc_enable = 0; tc_ais_en = 0; sw_force = 0;
   endtask

   // one insertion point; trig_exp is the bench's own qualified trigger
   task automatic ins_point(input logic trig_exp, input string req);
      logic exp;
      @(negedge clk);
      frame_num = 7'd74; n2_slot = 1'b1;
      #1;
      exp = trig_exp || (mrem > 0);
      chk({req, " strobe"}, odi_ins, 1'b1);
      chk(req, odi_val, exp);
      if (trig_exp) mrem = 9;
      else if (mrem > 0) mrem--;
      @(posedge clk);
      #1;
      n2_slot = 1'b0; frame_num = 7'd1;
   endtask

   // apply a setup, check one point, then drain the window with alarms off
   task automatic run_case(input logic trig_exp, input string req);
      ins_point(trig_exp, req);
      clear_alarms();
      for (int k = 0; k < 10; k++) ins_point(1'b0, trig_exp ? "R9" : req);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1: no alarm after reset gives no indication
      ins_point(1'b0, "R1");
      // R2 / R3 sweep of every frame, with and without the slot, forced on
      sw_force = 1'b1;
      for (int f = 1; f <= 76; f++) begin
         for (int s = 0; s < 2; s++) begin
            logic e;
            @(negedge clk);
            frame_num = 7'(f); n2_slot = logic'(s);
            #1;
            e = (s == 1) && (f == 74);
            chk("R2", odi_ins, e);
            chk("R3", odi_val, e);
            if (e) mrem = 9;
            @(posedge clk);
            #1 n2_slot = 1'b0;
         end
      end
      clear_alarms();
      for (int k = 0; k < 10; k++) ins_point(1'b0, "R9");
      // R4 direct alarms
      for (int i = 0; i < 6; i++) begin
         alm_direct = 6'(1 << i);
         run_case(1'b1, "R4");
      end
      // R5 gated alarms against their own and a neighbour's enable
      for (int i = 0; i < 5; i++) begin
         for (int e = 0; e < 3; e++) begin
            alm_gated = 5'(1 << i);
            gate_en = (e == 1) ? 5'(1 << i) : (e == 2) ? ~5'(1 << i) : 5'd0;
            run_case(e == 1, "R5");
         end
      end
      // R6 drop bus loss of clock and AIS
      for (int m = 0; m < 4; m++) begin
         drop_loc = m[0]; loc_en = m[1];
         run_case(m == 3, "R6");
      end
      for (int m = 0; m < 8; m++) begin
         drop_ais = m[0]; ais_en_a = m[1]; ais_en_b = m[2];
         run_case(m == 7, "R6");
      end
      // R7 TC AIS
      for (int m = 0; m < 8; m++) begin
         tc_ais = m[0]; tc_enable = m[1]; tc_ais_en = m[2];
         run_case(m == 7, "R7");
      end
      // R8 force held over several points
      sw_force = 1'b1;
      for (int k = 0; k < 3; k++) ins_point(1'b1, "R8");
      run_case(1'b1, "R8");
      // R10 retrigger mid window
      alm_direct = 6'd1;
      ins_point(1'b1, "R10");
      clear_alarms();
      for (int k = 0; k < 5; k++) ins_point(1'b0, "R10");
      alm_direct = 6'd4;
      ins_point(1'b1, "R10");
      clear_alarms();
      for (int k = 0; k < 10; k++) ins_point(1'b0, "R10");
      // R11 alarm only between insertion points
      @(negedge clk);
      alm_direct = 6'h3f; sw_force = 1'b1;
      frame_num = 7'd74; n2_slot = 1'b0;
      repeat (4) @(negedge clk);
      frame_num = 7'd73; n2_slot = 1'b1;
      #1 chk("R11", odi_val, 1'b0);
      repeat (3) @(negedge clk);
      n2_slot = 1'b0;
      clear_alarms();
      ins_point(1'b0, "R11");
      // R1 reset in the middle of a window
      alm_direct = 6'd2;
      ins_point(1'b1, "R1");
      clear_alarms();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      mrem = 0;
      ins_point(1'b0, "R1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule